// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a small first-in first-out store of instruction bytes filled ahead of need. It owns a sequential fetch pointer and, whenever the store has room and the execute side is not asking for the bus, it issues a single-byte memory read. The returned byte is appended to the tail and the pointer moves on by one. The execute side takes bytes from the head, one per read strobe. The oldest byte is always visible on the output.

The execute side raises an operand request when it needs the bus for its own data access. A prefetch that is already on the bus runs to completion first. After that, no new prefetch starts while the operand request stays high, and the block grants the bus to the execute side. When the store is full and no operand access is waiting, the bus sits idle.

A control transfer is handled with a one-cycle flush pulse that carries a target address. The flush empties the store and withdraws any outstanding read, whose data is thrown away. The fetch pointer is reloaded, so prefetching restarts from the target.

Top module: `prefetch_queue`

## Requirements
- R1: The store holds at most DEPTH bytes (default 6). `queueCount` reports the number held and never exceeds DEPTH.
- R2: A new prefetch starts only when `queueCount` is below DEPTH, `opReq` is low and `flush` is low while no read is outstanding. `memReq` rises on the next clock edge.
- R3: Once `memReq` is high, it stays high with `memAddr` unchanged until a cycle with `memAck` high or `flush` high. `opGrant` is high exactly when `opReq` is high and no read is outstanding, so a started prefetch completes before the operand access.
- R4: Bytes leave in arrival order. `popData` shows the oldest byte, and a cycle with `popReq` high on a non-empty store removes exactly one byte.
- R5: Each byte accepted with `memAck` is appended, and the fetch address then advances by one.
- R6: When no read is outstanding, the store is full and `opReq` is low, `memReq` stays low and `busIdle` is high. `busIdle` is high whenever `memReq` and `opReq` are both low.
- R7: A `flush` pulse empties the store and drops any outstanding read, discarding data acknowledged in that same cycle. The next fetch address becomes `flushAddr`.
- R8: `queueEmpty` is high exactly when `queueCount` is zero. A `popReq` while the store is empty changes nothing.
- R9: When a byte is appended and another removed in the same cycle, `queueCount` is unchanged.
- R10: After reset the store is empty, `memReq` is low and the fetch address equals RESET_ADDR (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle redirect pulse |
| flushAddr | input | ADDR_W | New fetch address taken with flush |
| popReq | input | 1 | Execute side takes the head byte |
| popData | output | DATA_W | Oldest byte in the store |
| queueEmpty | output | 1 | Store holds no bytes |
| queueCount | output | CNT_W | Number of bytes held |
| opReq | input | 1 | Execute side wants the bus for an operand access |
| opGrant | output | 1 | Bus is free for the operand access |
| busIdle | output | 1 | No fetch and no operand access on the bus |
| memReq | output | 1 | Prefetch read request |
| memAddr | output | ADDR_W | Fetch address, stable while memReq is high |
| memAck | input | 1 | Read data valid, ends the request |
| memData | input | DATA_W | Read data byte |

## Verification
The assertions assume that memory raises `memAck` only while `memReq` is high and holds it for a single cycle. They also assume that `flush` is a pulse whose target is presented in the same cycle. The bench memory acknowledges after a programmable wait, clears its acknowledge after each accepted cycle, and abandons a wait when the request is withdrawn. Reads, operand requests and flushes are driven with per-phase probabilities, so that fills to full, draining past empty, acknowledges that coincide with pops and flushes landing mid-fetch all occur.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } pfqStrobe_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl import pfq_pkg::*; #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             popReq,
  input  logic             opReq,
  input  logic             memAck,
  input  logic [CNT_W-1:0] queueCount,
  input  logic             queueEmpty,
  output logic             memReq,
  output logic             opGrant,
  output logic             busIdle,
  output pfqStrobe_t       strobe
);
  logic inFlight;
  logic roomLeft;

  assign roomLeft = queueCount < CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= 1'b0;
    else if (flush) inFlight <= 1'b0;
    else if (inFlight) inFlight <= !memAck;
    else inFlight <= roomLeft && !opReq;
  end

  always_comb begin
    strobe.clear = flush;
    strobe.push  = inFlight && memAck && !flush;
    strobe.pop   = popReq && !queueEmpty && !flush;
  end

  assign memReq  = inFlight;
  assign opGrant = opReq && !inFlight;
  assign busIdle = !inFlight && !opReq;
endmodule

// File: rtl/pfq_dpath.sv
module pfq_dpath import pfq_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic [ADDR_W-1:0] fetchPtr
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  rdIdx, wrIdx;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrIdx] <= memData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
      count <= '0;
      fetchPtr <= RESET_ADDR;
    end else if (strobe.clear) begin
      rdIdx <= '0;
      wrIdx <= '0;
      count <= '0;
      fetchPtr <= flushAddr;
    end else begin
      if (strobe.push) begin
        wrIdx <= nextIdx(wrIdx);
        fetchPtr <= fetchPtr + 1'b1;
      end
      if (strobe.pop) rdIdx <= nextIdx(rdIdx);
      case ({strobe.push, strobe.pop})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdIdx];
  assign empty = (count == '0);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue import pfq_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              queueEmpty,
  output logic [CNT_W-1:0]  queueCount,
  input  logic              opReq,
  output logic              opGrant,
  output logic              busIdle,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData
);
  pfqStrobe_t strobe;

  pfq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .popReq(popReq), .opReq(opReq),
    .memAck(memAck), .queueCount(queueCount), .queueEmpty(queueEmpty),
    .memReq(memReq), .opGrant(opGrant), .busIdle(busIdle), .strobe(strobe)
  );

  pfq_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .RESET_ADDR(RESET_ADDR)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flushAddr(flushAddr),
    .memData(memData), .headData(popData), .count(queueCount),
    .empty(queueEmpty), .fetchPtr(memAddr)
  );
endmodule

// File: rtl/prefetch_queue_checker.sv
module prefetch_queue_checker #(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic [ADDR_W-1:0] flushAddr,
  input logic              popReq,
  input logic              queueEmpty,
  input logic [CNT_W-1:0]  queueCount,
  input logic              opReq,
  input logic              opGrant,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    queueCount <= CNT_W'(DEPTH));

  assert_no_start_on_op_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memReq && opReq |=> !memReq);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !flush |=> memReq && $stable(memAddr));

  assert_grant_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    opGrant |-> !memReq);

  assert_addr_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !flush |=> memAddr == $past(memAddr) + 1'b1);

  assert_full_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memReq && queueCount == CNT_W'(DEPTH) |=> !memReq);

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> queueEmpty && !memReq && memAddr == $past(flushAddr));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    queueEmpty && popReq && !(memReq && memAck) |=> queueEmpty);

  assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && popReq && !queueEmpty && !flush |=> $stable(queueCount));
endmodule

bind prefetch_queue prefetch_queue_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .flush(flush), .flushAddr(flushAddr), .popReq(popReq),
  .queueEmpty(queueEmpty), .queueCount(queueCount), .opReq(opReq), .opGrant(opGrant),
  .memReq(memReq), .memAddr(memAddr), .memAck(memAck)
);

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;
  localparam int DEPTH = 6;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [ADDR_W-1:0] flushAddr = '0;
  logic popReq = 1'b0;
  logic opReq = 1'b0;
  logic memAck = 1'b0;
  logic [DATA_W-1:0] memData;
  logic [DATA_W-1:0] popData;
  logic queueEmpty, opGrant, busIdle, memReq;
  logic [CNT_W-1:0] queueCount;
  logic [ADDR_W-1:0] memAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int waitCnt = 0;
  int latency = 1;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [DATA_W-1:0] memByte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign memData = memByte(memAddr);

  prefetch_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .flushAddr(flushAddr), .popReq(popReq),
    .popData(popData), .queueEmpty(queueEmpty), .queueCount(queueCount),
    .opReq(opReq), .opGrant(opGrant), .busIdle(busIdle), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData)
  );

  // behavioural reference
  logic [DATA_W-1:0] mq[$];
  bit mBusy = 0;
  logic [ADDR_W-1:0] mAddr = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mq.delete();
      mBusy = 0;
      mAddr = '0;
    end else if (flush) begin
      mq.delete();
      mBusy = 0;
      mAddr = flushAddr;
    end else begin
      bit doPop, doPush, doStart;
      doPop = popReq && mq.size() > 0;
      doPush = mBusy && memAck;
      doStart = !mBusy && !opReq && mq.size() < DEPTH;
      if (doPop) void'(mq.pop_front());
      if (doPush) begin
        mq.push_back(memByte(mAddr));
        mAddr = mAddr + 1'b1;
        mBusy = 0;
      end else if (doStart) mBusy = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  task automatic compareAll();
    check(queueCount == CNT_W'(mq.size()), "R1 count", queueCount, mq.size());
    check(memReq == mBusy, "R2 memReq", memReq, mBusy);
    check(memAddr == mAddr, "R5 memAddr", memAddr, mAddr);
    check(opGrant == (opReq && !mBusy), "R3 opGrant", opGrant, opReq && !mBusy);
    check(busIdle == (!mBusy && !opReq), "R6 busIdle", busIdle, !mBusy && !opReq);
    check(queueEmpty == (mq.size() == 0), "R8 empty", queueEmpty, mq.size() == 0);
    if (mq.size() > 0) check(popData == mq[0], "R4 popData", popData, mq[0]);
  endtask

  // memory responder and comparison on every falling edge
  always @(negedge clk) begin
    if (rstN && !done) compareAll();
    if (memAck) begin
      memAck <= 1'b0;
      waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt + 1 >= latency) memAck <= 1'b1;
      waitCnt <= waitCnt + 1;
    end else waitCnt <= 0;
  end

  task automatic runPhase(input int n, input int popPct, input int opPct,
                          input int flushPct, input int lat);
    latency = lat;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      popReq = ($urandom_range(99, 0) < popPct);
      opReq = ($urandom_range(99, 0) < opPct);
      flush = ($urandom_range(99, 0) < flushPct);
      flushAddr = ADDR_W'($urandom);
    end
    @(negedge clk);
    #1;
    popReq = 0; opReq = 0; flush = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check(queueEmpty && queueCount == 0, "R10 reset empty", queueCount, 0);
    check(memAddr == '0, "R10 reset address", memAddr, 0);
    // fill to full with no consumer: R1, R2, R5, R6
    runPhase(30, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    #2;
    check(queueCount == CNT_W'(DEPTH), "R1 full count", queueCount, DEPTH);
    check(!memReq && busIdle, "R6 idle when full", memReq, 0);
    check(memAddr == ADDR_W'(DEPTH), "R5 address after fill", memAddr, DEPTH);
    check(popData == memByte('0), "R4 oldest first", popData, memByte('0));
    // drain with operand requests blocking prefetch, then pop past empty: R8, R2
    runPhase(12, 100, 100, 0, 1);
    @(negedge clk);
    #2;
    check(queueEmpty && queueCount == 0, "R8 pop while empty ignored", queueCount, 0);
    // redirect while idle: R7
    @(negedge clk); #1;
    opReq = 1; flush = 1; flushAddr = 20'h179B8;
    @(negedge clk); #1;
    flush = 0;
    #1;
    check(memAddr == 20'h179B8 && !memReq, "R7 redirect target", memAddr, 20'h179B8);
    opReq = 0;
    runPhase(10, 0, 0, 0, 2);
    check(popData == memByte(20'h179B8), "R7 first byte from target", popData, memByte(20'h179B8));
    // mixed traffic: R3, R4, R9
    runPhase(3000, 50, 20, 0, 1);
    runPhase(3000, 60, 10, 0, 3);
    runPhase(3000, 70, 0, 0, 1);
    // flush-heavy traffic with long latency: R7
    runPhase(3000, 40, 15, 8, 4);
    runPhase(2000, 50, 10, 5, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule